// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is a single DMA channel that performs block copies described by a linked list of descriptors in system memory. Software places the address of the first descriptor in the next-descriptor register and then sets the run bit of the control register. The channel first reads the whole eight-word descriptor into its working registers. It then copies the block one 32-bit word at a time, a read from the source followed by a write to the destination, and follows the link to the next descriptor. A link of zero ends the chain.

A status register reports whether the channel is busy and how the last chain ended: completed, stopped by software, or aborted on a bad descriptor. A level interrupt output follows a pending flag. That flag is set when a chain ends on a descriptor whose control word asks for it. Memory traffic uses a single-beat master port. The channel holds a request with its address and data until the memory acknowledges it, and the read data is taken in the acknowledge cycle.

Top module: `dmac_chain`

## Requirements
- R1: A write to CONTROL (reg_addr 0) with bit 0 set starts the channel only if STATUS bits 0 (active), 1 (chain done), 2 (halted) and 3 (aborted) are all clear. Otherwise the write causes no memory access and leaves STATUS unchanged, apart from the stored run bit.
- R2: Each descriptor is fetched as eight word reads at base, base+4 … base+28. Word 0 is the link, word 1 the source, word 2 the destination, word 3 the byte length and word 4 the control (bit 0 = interrupt enable). No data access happens before all eight reads have completed. The link is copied into NEXT (reg_addr 2) as it arrives.
- R3: A block of L bytes is moved as L/4 pairs. Each pair is a read of the source word followed by a write of that data to the destination word. Both addresses rise by 4 per pair.
- R4: A non-zero link makes the channel fetch the next descriptor after the block. A block of length zero moves no data.
- R5: A zero link ends the chain. STATUS bit 1 is set, bit 0 is cleared, and STATUS bit 4 (interrupt pending) is set if the last descriptor's control bit 0 was 1.
- R6: A start or link address whose low five bits are not zero sets STATUS bit 3, leaves bit 0 clear and issues no memory access for that descriptor.
- R7: A length whose low two bits are not zero sets STATUS bit 3 after the fetch and moves no data.
- R8: Clearing CONTROL bit 0 while active lets the outstanding access complete. The channel then sets STATUS bit 2, clears bit 0 and issues no further access.
- R9: STATUS bits 1 to 4 clear when written with 1. Bit 0 is read-only. The irq pin equals STATUS bit 4.
- R10: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata unchanged until the cycle in which mem_ack is high.
- R11: STATUS bit 0 is high from an accepted start until a terminal state. It is never high together with bits 1 to 3, and mem_req is only high while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset: 0 control, 1 status, 2 next, 3 source, 4 destination, 5 remaining length |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request in this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| irq | output | 1 | Interrupt, high while STATUS bit 4 is set |

## Verification
The properties assume that the memory only raises mem_ack while a request is pending. They also assume that software writes CONTROL and STATUS through the register port at one write per cycle. The bench memory model acknowledges a pending request on the following cycle and never otherwise. Register writes come from a single task that holds reg_we for exactly one clock. Descriptor, source and destination regions are kept apart, so the expected read data stays the preloaded contents.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned KEPT_WORDS = 4;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_NEXT = 3'd2;
  localparam logic [2:0] RA_SRC  = 3'd3;
  localparam logic [2:0] RA_DST  = 3'd4;
  localparam logic [2:0] RA_LEN  = 3'd5;

  localparam int unsigned SB_ACT  = 0;
  localparam int unsigned SB_DONE = 1;
  localparam int unsigned SB_HALT = 2;
  localparam int unsigned SB_ABRT = 3;
  localparam int unsigned SB_IRQ  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_LINK
  } eng_state_e;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          eng_active,
  input  logic          set_done,
  input  logic          set_halt,
  input  logic          set_abort,
  input  logic          set_irq,
  input  logic          nxt_load,
  input  logic [AW-1:0] nxt_val,
  input  logic [AW-1:0] cur_src,
  input  logic [AW-1:0] cur_dst,
  input  logic [AW-1:0] cur_len,
  output logic          run,
  output logic          start,
  output logic [AW-1:0] next_addr,
  output logic [4:0]    status,
  output logic          irq
);
  logic          run_q, run_d;
  logic          done_q, done_d, halt_q, halt_d, abrt_q, abrt_d, irq_q, irq_d;
  logic [AW-1:0] next_q, next_d;
  logic          wr_ctrl, wr_stat, wr_next;

  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_stat = reg_we && (reg_addr == RA_STAT);
  assign wr_next = reg_we && (reg_addr == RA_NEXT);

  assign start = wr_ctrl && reg_wdata[0] && !(eng_active || done_q || halt_q || abrt_q);

  always_comb begin
    run_d  = wr_ctrl ? reg_wdata[0] : run_q;
    done_d = set_done  || (done_q && !(wr_stat && reg_wdata[SB_DONE]));
    halt_d = set_halt  || (halt_q && !(wr_stat && reg_wdata[SB_HALT]));
    abrt_d = set_abort || (abrt_q && !(wr_stat && reg_wdata[SB_ABRT]));
    irq_d  = set_irq   || (irq_q  && !(wr_stat && reg_wdata[SB_IRQ]));
    next_d = next_q;
    if (nxt_load)     next_d = nxt_val;
    else if (wr_next) next_d = reg_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      halt_q <= 1'b0;
      abrt_q <= 1'b0;
      irq_q  <= 1'b0;
      next_q <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      halt_q <= halt_d;
      abrt_q <= abrt_d;
      irq_q  <= irq_d;
      if (nxt_load || wr_next) next_q <= next_d;
    end
  end

  assign status    = {irq_q, abrt_q, halt_q, done_q, eng_active};
  assign run       = run_q;
  assign next_addr = next_q;
  assign irq       = irq_q;

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {{(DW-1){1'b0}}, run_q};
      RA_STAT: reg_rdata = {{(DW-5){1'b0}}, status};
      RA_NEXT: reg_rdata = next_q;
      RA_SRC:  reg_rdata = cur_src;
      RA_DST:  reg_rdata = cur_dst;
      RA_LEN:  reg_rdata = cur_len;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic [AW-1:0] next_addr,
  output logic          active,
  output logic          set_done,
  output logic          set_halt,
  output logic          set_abort,
  output logic          set_irq,
  output logic          nxt_load,
  output logic [AW-1:0] nxt_val,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [AW-1:0] cur_len,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int unsigned ALIGN_W = $clog2(DESC_WORDS) + 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  eng_state_e     state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]  base_q, base_d, src_q, dst_q, len_q;
  logic [DW-1:0]  buf_q;
  logic [DW-1:0]  word_q [KEPT_WORDS];
  logic           ien_q;
  logic           idx_clr, idx_inc, base_ld, cap, ld_work, step, buf_ld;

  always_comb begin
    state_d   = state_q;
    base_d    = base_q;
    idx_clr   = 1'b0;
    idx_inc   = 1'b0;
    base_ld   = 1'b0;
    cap       = 1'b0;
    ld_work   = 1'b0;
    step      = 1'b0;
    buf_ld    = 1'b0;
    set_done  = 1'b0;
    set_halt  = 1'b0;
    set_abort = 1'b0;
    set_irq   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    case (state_q)
      ST_IDLE: if (start) begin
        if (next_addr[ALIGN_W-1:0] != '0) set_abort = 1'b1;
        else begin
          base_d = next_addr; base_ld = 1'b1; idx_clr = 1'b1; state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = base_q + {{(AW-IDX_W-2){1'b0}}, idx_q, 2'b00};
        if (mem_ack) begin
          cap     = 1'b1;
          idx_inc = 1'b1;
          if (!run) begin set_halt = 1'b1; state_d = ST_IDLE; end
          else if (idx_q == LAST_IDX) state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (word_q[3][1:0] != 2'b00) begin set_abort = 1'b1; state_d = ST_IDLE; end
        else if (!run) begin set_halt = 1'b1; state_d = ST_IDLE; end
        else begin
          ld_work = 1'b1;
          state_d = (word_q[3] == '0) ? ST_LINK : ST_READ;
        end
      end
      ST_READ: begin
        mem_req  = 1'b1;
        mem_addr = src_q;
        if (mem_ack) begin
          buf_ld  = 1'b1;
          state_d = run ? ST_WRITE : ST_IDLE;
          set_halt = !run;
        end
      end
      ST_WRITE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_q;
        if (mem_ack) begin
          step = 1'b1;
          if (!run) begin set_halt = 1'b1; state_d = ST_IDLE; end
          else if (len_q == AW'(4)) state_d = ST_LINK;
          else state_d = ST_READ;
        end
      end
      ST_LINK: begin
        if (word_q[0] == '0) begin
          set_done = 1'b1; set_irq = ien_q; state_d = ST_IDLE;
        end else if (!run) begin
          set_halt = 1'b1; state_d = ST_IDLE;
        end else if (word_q[0][ALIGN_W-1:0] != '0) begin
          set_abort = 1'b1; state_d = ST_IDLE;
        end else begin
          base_d = word_q[0]; base_ld = 1'b1; idx_clr = 1'b1; state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      buf_q   <= '0;
      ien_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idx_clr)      idx_q <= '0;
      else if (idx_inc) idx_q <= idx_q + 1'b1;
      if (base_ld) base_q <= base_d;
      if (buf_ld)  buf_q  <= mem_rdata;
      if (cap && idx_q == IDX_W'(4)) ien_q <= mem_rdata[0];
      if (ld_work) begin
        src_q <= word_q[1];
        dst_q <= word_q[2];
        len_q <= word_q[3];
      end else if (step) begin
        src_q <= src_q + AW'(4);
        dst_q <= dst_q + AW'(4);
        len_q <= len_q - AW'(4);
      end
    end
  end

  for (genvar g = 0; g < KEPT_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word_q[g] <= '0;
      else if (cap && idx_q == IDX_W'(g))  word_q[g] <= mem_rdata;
    end
  end

  assign active    = (state_q != ST_IDLE);
  assign mem_wdata = buf_q;
  assign nxt_load  = cap && (idx_q == '0);
  assign nxt_val   = mem_rdata;
  assign cur_src   = src_q;
  assign cur_dst   = dst_q;
  assign cur_len   = len_q;
endmodule

// File: rtl/dmac_chain.sv
module dmac_chain
  import dmac_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          run, start, eng_active;
  logic          set_done, set_halt, set_abort, set_irq, nxt_load;
  logic [AW-1:0] next_addr, nxt_val, cur_src, cur_dst, cur_len;
  logic [4:0]    status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dmac_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_active(eng_active), .set_done(set_done), .set_halt(set_halt),
    .set_abort(set_abort), .set_irq(set_irq), .nxt_load(nxt_load), .nxt_val(nxt_val),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_len(cur_len),
    .run(run), .start(start), .next_addr(next_addr), .status(status), .irq(irq)
  );

  dmac_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_int_n),
    .start(start), .run(run), .next_addr(next_addr), .active(eng_active),
    .set_done(set_done), .set_halt(set_halt), .set_abort(set_abort), .set_irq(set_irq),
    .nxt_load(nxt_load), .nxt_val(nxt_val),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_len(cur_len),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/dmac_chain_chk.sv
module dmac_chain_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [4:0]    status,
  input logic          irq
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R11
  active_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && (status[3:1] != 3'b000)));

  // R11
  req_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> status[0]);

  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata[0] && (status[3:0] != 4'b0000))
      |=> (status[0] == $past(status[0])));

  // R5
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> status[1]);
endmodule

bind dmac_chain dmac_chain_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .status(status), .irq(irq)
);

// File: tb/dmac_chain_bench.sv
module dmac_chain_bench;
  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } xact_t;

  logic        clk, rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;

  logic [31:0] mem [256];
  xact_t       exp_q [$];
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          loose    = 0;
  int          loose_wr = 0;
  int          cyc      = 0;

  dmac_chain u_dmac_chain (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares every completed memory access with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (loose) begin
        if (mem_we) loose_wr++;
      end else if (exp_q.size() == 0) begin
        check("R1/R6 unexpected access addr", mem_addr, 32'hFFFF_FFFF);
      end else begin
        xact_t e;
        e = exp_q.pop_front();
        check("R2/R3 access kind", {31'b0, mem_we}, {31'b0, e.we});
        check("R2/R3 access address", mem_addr, e.addr);
        check("R2/R3 access data", mem_we ? mem_wdata : mem_rdata, e.data);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      rd_reg(3'd1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic set_desc(input int base, input logic [31:0] lnk, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] len, input logic [31:0] ctl);
    mem[base/4+0] = lnk; mem[base/4+1] = src; mem[base/4+2] = dst;
    mem[base/4+3] = len; mem[base/4+4] = ctl;
    mem[base/4+5] = 32'h5A5A_0005; mem[base/4+6] = 32'h5A5A_0006; mem[base/4+7] = 32'h5A5A_0007;
  endtask

  // driver: pushes the expected transactions for one descriptor
  task automatic push_fetch(input int base);
    for (int i = 0; i < 8; i++) exp_q.push_back('{1'b0, 32'(base + 4*i), mem[base/4+i]});
  endtask

  task automatic push_copy(input int src, input int dst, input int len);
    for (int i = 0; i < len/4; i++) begin
      exp_q.push_back('{1'b0, 32'(src + 4*i), mem[src/4+i]});
      exp_q.push_back('{1'b1, 32'(dst + 4*i), mem[src/4+i]});
    end
  endtask

  initial begin
    logic [31:0] s;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i * 32'h0101);
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    // reset state
    rd_reg(3'd1, s); check("R11 reset status", s, 32'h0);
    check("R9 reset irq", {31'b0, irq}, 32'h0);
    check("R10 reset mem_req", {31'b0, mem_req}, 32'h0);

    // single block, interrupt enabled
    set_desc(32'h000, 32'h0, 32'h200, 32'h300, 32'd12, 32'h1);
    push_fetch(32'h000); push_copy(32'h200, 32'h300, 12);
    wr_reg(3'd2, 32'h000);
    wr_reg(3'd0, 32'h1);
    rd_reg(3'd1, s); check("R11 active after start", {31'b0, s[0]}, 32'h1);
    wait_idle();
    check("R2/R3 scoreboard drained", exp_q.size(), 0);
    rd_reg(3'd1, s); check("R5 status done+irq", s, 32'h12);
    check("R9 irq pin", {31'b0, irq}, 32'h1);
    check("R3 last dst word", mem[32'h308/4], mem[32'h208/4]);

    // start while done set is ignored
    wr_reg(3'd0, 32'h1);
    repeat (12) @(negedge clk);
    rd_reg(3'd1, s); check("R1 gated start keeps status", s, 32'h12);
    wr_reg(3'd1, 32'h1E);
    rd_reg(3'd1, s); check("R9 write-one clear", s, 32'h0);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);

    // three-descriptor chain with a zero-length block, no interrupt
    set_desc(32'h040, 32'h060, 32'h210, 32'h320, 32'd8, 32'h0);
    set_desc(32'h060, 32'h080, 32'h2F0, 32'h3F0, 32'd0, 32'h1);
    set_desc(32'h080, 32'h0,   32'h218, 32'h340, 32'd4, 32'h0);
    push_fetch(32'h040); push_copy(32'h210, 32'h320, 8);
    push_fetch(32'h060); push_fetch(32'h080); push_copy(32'h218, 32'h340, 4);
    wr_reg(3'd2, 32'h040);
    wr_reg(3'd0, 32'h1);
    wait_idle();
    check("R4 chain scoreboard drained", exp_q.size(), 0);
    rd_reg(3'd1, s); check("R5 chain done, no irq", s, 32'h02);
    check("R5 irq low", {31'b0, irq}, 32'h0);
    rd_reg(3'd2, s); check("R2 next holds last link", s, 32'h0);
    wr_reg(3'd1, 32'h1E);

    // misaligned start address
    wr_reg(3'd2, 32'h044);
    wr_reg(3'd0, 32'h1);
    repeat (6) @(negedge clk);
    rd_reg(3'd1, s); check("R6 misaligned aborts", s, 32'h08);
    wr_reg(3'd1, 32'h1E);

    // length not a multiple of four
    set_desc(32'h0A0, 32'h0, 32'h220, 32'h360, 32'd6, 32'h1);
    push_fetch(32'h0A0);
    wr_reg(3'd2, 32'h0A0);
    wr_reg(3'd0, 32'h1);
    wait_idle();
    repeat (4) @(negedge clk);
    check("R7 only fetch seen", exp_q.size(), 0);
    rd_reg(3'd1, s); check("R7 bad length aborts", s, 32'h08);
    wr_reg(3'd1, 32'h1E);

    // stop in the middle of a copy
    set_desc(32'h0C0, 32'h0, 32'h280, 32'h380, 32'd64, 32'h1);
    loose = 1; loose_wr = 0;
    wr_reg(3'd2, 32'h0C0);
    wr_reg(3'd0, 32'h1);
    repeat (30) @(negedge clk);
    wr_reg(3'd0, 32'h0);
    wait_idle();
    repeat (4) @(negedge clk);
    rd_reg(3'd1, s); check("R8 halted status", s, 32'h04);
    check("R8 no request after halt", {31'b0, mem_req}, 32'h0);
    check("R8 copy cut short", {31'b0, (loose_wr > 0 && loose_wr < 16)}, 32'h1);
    loose = 0;
    wr_reg(3'd1, 32'h1E);
    rd_reg(3'd1, s); check("R9 halted cleared", s, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule